// File: doc/BRIEF.md
# Ingress Address Window Mapper

This block sits on the inbound side of an I/O bridge. Each read or write request that arrives from the external bus is compared by its bus address against a table of programmable windows. The first enabled window that covers the address translates the request into a local target address and tags it with the window's translation context. The window's ordering policy then decides whether the request may go downstream now or must wait until earlier writes to that window have completed. A request that no window covers is consumed and reported as a miss. It is never forwarded.

Windows are 4 kB granular. The start address, the size and the target base are all held as page numbers, so the 12 bits below the page boundary pass through untouched. Each window keeps its own outstanding-write counter. The counter rises when a write from that window is accepted and falls when the memory side returns a completion naming that window.

The request input and the translated output are valid/ready streams. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. A miss is always accepted. A hit is accepted only when its window's ordering policy allows it and the single output register is empty or draining in that cycle. While `out_valid` is high and `out_ready` is low, every output field holds its value. Configuration and completion pins are plain single-cycle strobes.

Top module: `ingress_window_map`

## Requirements
- R1: After reset `out_valid` and `miss_o` are low and every window is disabled, so every request is treated as a miss.
- R2: A request hits window i when the window is enabled and the address page (address bits 47:12) lies in the range from `cfg_bus_pg` up to, but not including, `cfg_bus_pg + cfg_npg`. A window with a page count of 0 never hits, and a window that has been disabled by reconfiguration never hits.
- R3: On a hit, `out_addr` equals the target page plus the page offset from the window start, concatenated with the unchanged low 12 address bits. `out_ctx` carries the window's context, and `out_write` and `out_len` carry the request's values.
- R4: When windows overlap, the enabled window with the lowest index supplies the translation.
- R5: A miss is accepted in the cycle it is presented, even while the output register is full. It never raises `out_valid`, and `miss_o` is high for exactly the next cycle.
- R6: An accepted hit appears on the output in the next cycle. While `out_valid` is high and `out_ready` is low, the output fields are stable and no further hit is accepted.
- R7: Ordering mode 0 (unordered): a write is accepted while earlier writes of its window are outstanding. A read waits until its window's outstanding-write count is zero.
- R8: Ordering mode 1 (strict): both reads and writes wait until the window's outstanding-write count is zero. Mode value 3 behaves the same way.
- R9: Ordering mode 2 (packet-directed): a write with `req_relaxed` set proceeds while writes are outstanding. A write without it, and any read, waits for a count of zero.
- R10: A window's count increments on each accepted write to that window and decrements on a `cpl_valid` strobe carrying that window's index. A completion at a count of zero is ignored, and the counts of different windows are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one window entry |
| cfg_idx | input | 3 | Window index to write |
| cfg_en | input | 1 | Window enable |
| cfg_mode | input | 2 | Ordering mode: 0 unordered, 1 strict, 2 packet-directed, 3 strict |
| cfg_ctx | input | 4 | Translation context tag |
| cfg_bus_pg | input | 36 | First bus page of the window |
| cfg_npg | input | 36 | Window size in 4 kB pages |
| cfg_tgt_pg | input | 36 | First target page |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_addr | input | 48 | Bus byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 12 | Request length, passed through |
| req_relaxed | input | 1 | Relaxed-ordering attribute of the request |
| out_valid | output | 1 | Translated request valid |
| out_ready | input | 1 | Downstream accepts the translated request |
| out_addr | output | 48 | Translated target address |
| out_write | output | 1 | Request direction |
| out_len | output | 12 | Request length |
| out_ctx | output | 4 | Translation context of the window |
| out_win | output | 3 | Index of the matching window |
| miss_o | output | 1 | One-cycle pulse after a miss is consumed |
| cpl_valid | input | 1 | Completion of one write |
| cpl_win | input | 3 | Window index of the completed write |

## Verification
The assertions check on every cycle that the output holds under back-pressure, that no hit enters a full output register, that the low address bits survive translation, that a consumed miss raises `miss_o` and nothing else, and that no read ever leaves while its window still has outstanding writes. The bench's scenarios are needed to show which window wins an overlap, the arithmetic of translation across a sweep of pages, and the per-mode rules about when writes may pass. They also cover counter underflow protection and the independence of the windows, because all of these depend on programmed tables and sequences of events.

// File: rtl/iwm_pkg.sv
package iwm_pkg;
  localparam int PAGE_BITS = 12;
  typedef enum logic [1:0] {
    ORD_UNORD  = 2'd0,
    ORD_STRICT = 2'd1,
    ORD_OBEY   = 2'd2,
    ORD_STRICT_ALT = 2'd3
  } ord_mode_e;
endpackage

// File: rtl/iwm_match.sv
module iwm_match #(
  parameter int NUM_WIN = 8,
  parameter int PG_W    = 36,
  parameter int CTX_W   = 4,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0]            win_en,
  input  logic [NUM_WIN-1:0][PG_W-1:0]  win_bus,
  input  logic [NUM_WIN-1:0][PG_W-1:0]  win_npg,
  input  logic [NUM_WIN-1:0][PG_W-1:0]  win_tgt,
  input  logic [NUM_WIN-1:0][CTX_W-1:0] win_ctx,
  input  logic [NUM_WIN-1:0][1:0]       win_mode,
  input  logic [PG_W-1:0]               req_pg,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o,
  output logic [PG_W-1:0]               tgt_pg_o,
  output logic [CTX_W-1:0]              ctx_o,
  output logic [1:0]                    mode_o
);
  logic [NUM_WIN-1:0]           w_hit;
  logic [NUM_WIN-1:0][PG_W-1:0] w_tgt;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic [PG_W-1:0] off;
    assign off      = req_pg - win_bus[i];
    assign w_hit[i] = win_en[i] && (req_pg >= win_bus[i]) && (off < win_npg[i]);
    assign w_tgt[i] = win_tgt[i] + off;
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (w_hit[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  assign tgt_pg_o = w_tgt[idx_o];
  assign ctx_o    = win_ctx[idx_o];
  assign mode_o   = win_mode[idx_o];
endmodule

// File: rtl/iwm_order.sv
module iwm_order
  import iwm_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int CNT_W   = 6,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] dom_idx,
  input  logic [1:0]       mode,
  input  logic             is_wr,
  input  logic             relaxed,
  input  logic             acc_wr,
  input  logic             cpl_valid,
  input  logic [IDX_W-1:0] cpl_idx,
  output logic             allow,
  output logic             dom_zero
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_WIN-1:0][CNT_W-1:0] cnt;
  logic                          dom_full;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cnt
    logic inc, dec;
    assign inc = acc_wr && (dom_idx == IDX_W'(i));
    assign dec = cpl_valid && (cpl_idx == IDX_W'(i)) && (cnt[i] != '0);
    always_ff @(posedge clk) begin
      if (!rst_n)          cnt[i] <= '0;
      else if (inc && !dec) cnt[i] <= cnt[i] + 1'b1;
      else if (dec && !inc) cnt[i] <= cnt[i] - 1'b1;
    end
  end

  assign dom_zero = (cnt[dom_idx] == '0);
  assign dom_full = (cnt[dom_idx] == CNT_MAX);

  always_comb begin
    unique case (ord_mode_e'(mode))
      ORD_UNORD: allow = is_wr ? !dom_full : dom_zero;
      ORD_OBEY:  allow = (is_wr && relaxed) ? !dom_full : dom_zero;
      default:   allow = dom_zero;
    endcase
  end
endmodule

// File: rtl/ingress_window_map.sv
module ingress_window_map
  import iwm_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int ADDR_W  = 48,
  parameter int LEN_W   = 12,
  parameter int CTX_W   = 4,
  parameter int CNT_W   = 6,
  localparam int IDX_W  = $clog2(NUM_WIN),
  localparam int PG_W   = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_mode,
  input  logic [CTX_W-1:0]  cfg_ctx,
  input  logic [PG_W-1:0]   cfg_bus_pg,
  input  logic [PG_W-1:0]   cfg_npg,
  input  logic [PG_W-1:0]   cfg_tgt_pg,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_relaxed,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_write,
  output logic [LEN_W-1:0]  out_len,
  output logic [CTX_W-1:0]  out_ctx,
  output logic [IDX_W-1:0]  out_win,
  output logic              miss_o,
  input  logic              cpl_valid,
  input  logic [IDX_W-1:0]  cpl_win
);
  logic [NUM_WIN-1:0]            win_en;
  logic [NUM_WIN-1:0][PG_W-1:0]  win_bus, win_npg, win_tgt;
  logic [NUM_WIN-1:0][CTX_W-1:0] win_ctx;
  logic [NUM_WIN-1:0][1:0]       win_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_en   <= '0;
      win_bus  <= '0;
      win_npg  <= '0;
      win_tgt  <= '0;
      win_ctx  <= '0;
      win_mode <= '0;
    end else if (cfg_we) begin
      win_en[cfg_idx]   <= cfg_en;
      win_bus[cfg_idx]  <= cfg_bus_pg;
      win_npg[cfg_idx]  <= cfg_npg;
      win_tgt[cfg_idx]  <= cfg_tgt_pg;
      win_ctx[cfg_idx]  <= cfg_ctx;
      win_mode[cfg_idx] <= cfg_mode;
    end
  end

  logic             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  logic [PG_W-1:0]  dec_tgt;
  logic [CTX_W-1:0] dec_ctx;
  logic [1:0]       dec_mode;

  iwm_match #(.NUM_WIN(NUM_WIN), .PG_W(PG_W), .CTX_W(CTX_W)) u_match (
    .win_en(win_en), .win_bus(win_bus), .win_npg(win_npg), .win_tgt(win_tgt),
    .win_ctx(win_ctx), .win_mode(win_mode),
    .req_pg(req_addr[ADDR_W-1:PAGE_BITS]),
    .hit_o(dec_hit), .idx_o(dec_idx), .tgt_pg_o(dec_tgt), .ctx_o(dec_ctx),
    .mode_o(dec_mode)
  );

  logic acc, acc_hit, ord_allow, ord_zero, slot_free;

  assign slot_free = !out_valid || out_ready;
  assign req_ready = !dec_hit || (ord_allow && slot_free);
  assign acc       = req_valid && req_ready;
  assign acc_hit   = acc && dec_hit;

  iwm_order #(.NUM_WIN(NUM_WIN), .CNT_W(CNT_W)) u_order (
    .clk(clk), .rst_n(rst_n), .dom_idx(dec_idx), .mode(dec_mode),
    .is_wr(req_write), .relaxed(req_relaxed), .acc_wr(acc_hit && req_write),
    .cpl_valid(cpl_valid), .cpl_idx(cpl_win),
    .allow(ord_allow), .dom_zero(ord_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_write <= 1'b0;
      out_len   <= '0;
      out_ctx   <= '0;
      out_win   <= '0;
      miss_o    <= 1'b0;
    end else begin
      miss_o <= acc && !dec_hit;
      if (acc_hit) begin
        out_valid <= 1'b1;
        out_addr  <= {dec_tgt, req_addr[PAGE_BITS-1:0]};
        out_write <= req_write;
        out_len   <= req_len;
        out_ctx   <= dec_ctx;
        out_win   <= dec_idx;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/iwm_chk.sv
module iwm_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_write,
  input logic              miss_o,
  input logic              hit,
  input logic              dom_zero
);
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_write));

  // R6
  slot_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && hit |-> !out_valid || out_ready);

  // R3
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && hit |=> out_valid && out_addr[11:0] == $past(req_addr[11:0]));

  // R5
  miss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !hit |=> miss_o);

  // R7
  read_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && hit && !req_write |-> dom_zero);
endmodule

bind ingress_window_map iwm_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_write(req_write), .out_valid(out_valid),
  .out_ready(out_ready), .out_addr(out_addr), .out_write(out_write),
  .miss_o(miss_o), .hit(dec_hit), .dom_zero(ord_zero)
);

// File: tb/ingress_window_map_test.sv
module ingress_window_map_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic        cfg_en = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [3:0]  cfg_ctx = '0;
  logic [35:0] cfg_bus_pg = '0, cfg_npg = '0, cfg_tgt_pg = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [47:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [11:0] req_len = '0;
  logic        req_relaxed = 1'b0;
  logic        out_valid, out_ready = 1'b1;
  logic [47:0] out_addr;
  logic        out_write;
  logic [11:0] out_len;
  logic [3:0]  out_ctx;
  logic [2:0]  out_win;
  logic        miss_o;
  logic        cpl_valid = 1'b0;
  logic [2:0]  cpl_win = '0;

  int n_tests = 0, n_fail = 0, cycles = 0;

  // bench copy of the programmed windows
  logic        m_en  [8];
  logic [35:0] m_bus [8], m_npg [8], m_tgt [8];
  logic [3:0]  m_ctx [8];

  ingress_window_map uut (.*);

  always #4 clk = ~clk;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_win(input int i, input bit en, input logic [1:0] mode, input logic [3:0] ctx,
                         input logic [35:0] bus, input logic [35:0] npg, input logic [35:0] tgt);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(i); cfg_en = en; cfg_mode = mode; cfg_ctx = ctx;
    cfg_bus_pg = bus; cfg_npg = npg; cfg_tgt_pg = tgt;
    m_en[i] = en; m_bus[i] = bus; m_npg[i] = npg; m_tgt[i] = tgt; m_ctx[i] = ctx;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // present a request for one cycle without letting it be accepted; return ready
  task automatic probe(input logic [47:0] a, input bit wr, input bit rel, output bit rdy);
    @(negedge clk);
    req_addr = a; req_write = wr; req_relaxed = rel; req_valid = 1;
    #1 rdy = req_ready;
    req_valid = 0;
  endtask

  // present a request for exactly one edge (caller knows it is accepted)
  task automatic send(input logic [47:0] a, input bit wr, input bit rel, input logic [11:0] len);
    @(negedge clk);
    req_addr = a; req_write = wr; req_relaxed = rel; req_len = len; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic complete(input int w);
    @(negedge clk);
    cpl_valid = 1; cpl_win = 3'(w);
    @(negedge clk);
    cpl_valid = 0;
  endtask

  // expected result computed from the window table
  task automatic expect_rd(input logic [47:0] a, input logic [11:0] len);
    bit hit = 0; int w = 0;
    logic [35:0] pg = a[47:12];
    logic [47:0] ea;
    bit rdy;
    for (int i = 7; i >= 0; i--)
      if (m_en[i] && pg >= m_bus[i] && (pg - m_bus[i]) < m_npg[i]) begin hit = 1; w = i; end
    @(negedge clk);
    req_addr = a; req_write = 0; req_relaxed = 0; req_len = len; req_valid = 1;
    #1 rdy = req_ready;
    check(rdy, "R2 ready on read", 64'(rdy), 1);
    @(negedge clk);
    req_valid = 0;
    if (hit) begin
      ea = {m_tgt[w] + (pg - m_bus[w]), a[11:0]};
      check(out_valid && !miss_o, "R2 hit expected", {62'd0, out_valid, miss_o}, 2);
      check(out_addr == ea, "R3/R4 translated address", 64'(out_addr), 64'(ea));
      check(out_ctx == m_ctx[w] && out_win == 3'(w) && out_len == len && !out_write,
            "R3/R4 fields", {45'd0, out_win, out_ctx, out_len}, {45'd0, 3'(w), m_ctx[w], len});
    end else begin
      check(!out_valid && miss_o, "R5 miss expected", {62'd0, out_valid, miss_o}, 1);
    end
  endtask

  initial begin
    bit rdy;
    for (int i = 0; i < 8; i++) begin
      m_en[i] = 0; m_bus[i] = 0; m_npg[i] = 0; m_tgt[i] = 0; m_ctx[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(!out_valid && !miss_o, "R1 reset outputs", {62'd0, out_valid, miss_o}, 0);
    expect_rd(48'h0001_0000_0123, 12'd4); // R1: every request misses
    @(negedge clk);
    check(!miss_o, "R5 miss pulse one cycle", 64'(miss_o), 0);

    set_win(0, 1, 2'd0, 4'd1, 36'h10, 36'd4, 36'h800);
    set_win(1, 1, 2'd1, 4'd2, 36'h12, 36'd8, 36'h2000);   // overlaps window 0 at 0x12-0x13
    set_win(2, 1, 2'd2, 4'd3, 36'h40, 36'd1, 36'hABCDE);
    set_win(3, 0, 2'd0, 4'd4, 36'h50, 36'd2, 36'h9000);
    set_win(4, 1, 2'd0, 4'd5, 36'h60, 36'd0, 36'h7000);   // zero size

    // R2 R3 R4 sweep over pages around every window
    for (int p = 'h0E; p <= 'h1C; p++)
      expect_rd({36'(p), 12'((p * 37) & 'hfff)}, 12'(p));
    for (int p = 'h3F; p <= 'h52; p++)
      expect_rd({36'(p), 12'((p * 101) & 'hfff)}, 12'(p + 3));
    expect_rd({36'h60, 12'h010}, 12'd1); // R2 zero-size window
    expect_rd({36'hF_0000_0012, 12'h0}, 12'd1); // R2 high bits must match

    // R7 unordered: writes pass, reads wait
    send({36'h10, 12'h004}, 1, 0, 12'd8);
    check(out_valid && out_write && out_addr == {36'h800, 12'h004}, "R3 write forwarded",
          64'(out_addr), 64'({36'h800, 12'h004}));
    probe({36'h11, 12'h0}, 1, 0, rdy); check(rdy, "R7 second write passes", 64'(rdy), 1);
    send({36'h11, 12'h0}, 1, 0, 12'd8);
    send({36'h13, 12'h0}, 1, 0, 12'd8);
    probe({36'h10, 12'h100}, 0, 0, rdy); check(!rdy, "R7 read waits", 64'(rdy), 0);
    probe({36'h40, 12'h0}, 0, 0, rdy); check(rdy, "R10 other window independent", 64'(rdy), 1);
    complete(0); complete(0);
    probe({36'h10, 12'h100}, 0, 0, rdy); check(!rdy, "R10 one write still open", 64'(rdy), 0);
    complete(0);
    probe({36'h10, 12'h100}, 0, 0, rdy); check(rdy, "R10 count back to zero", 64'(rdy), 1);
    complete(0); // at zero: ignored
    send({36'h10, 12'h0}, 1, 0, 12'd8);
    probe({36'h10, 12'h100}, 0, 0, rdy); check(!rdy, "R10 completion at zero ignored", 64'(rdy), 0);
    complete(0);

    // R8 strict
    send({36'h14, 12'h0}, 1, 0, 12'd8);
    probe({36'h15, 12'h0}, 1, 0, rdy); check(!rdy, "R8 write waits", 64'(rdy), 0);
    probe({36'h15, 12'h0}, 1, 1, rdy); check(!rdy, "R8 relaxed write waits", 64'(rdy), 0);
    probe({36'h15, 12'h0}, 0, 0, rdy); check(!rdy, "R8 read waits", 64'(rdy), 0);
    complete(1);
    probe({36'h15, 12'h0}, 1, 0, rdy); check(rdy, "R8 write after completion", 64'(rdy), 1);
    set_win(5, 1, 2'd3, 4'd6, 36'h70, 36'd1, 36'h100);
    send({36'h70, 12'h0}, 1, 1, 12'd8);
    probe({36'h70, 12'h0}, 1, 1, rdy); check(!rdy, "R8 mode 3 strict", 64'(rdy), 0);
    complete(5);

    // R9 packet-directed
    send({36'h40, 12'h0}, 1, 0, 12'd8);
    probe({36'h40, 12'h8}, 1, 1, rdy); check(rdy, "R9 relaxed write passes", 64'(rdy), 1);
    probe({36'h40, 12'h8}, 1, 0, rdy); check(!rdy, "R9 ordered write waits", 64'(rdy), 0);
    probe({36'h40, 12'h8}, 0, 0, rdy); check(!rdy, "R9 read waits", 64'(rdy), 0);
    complete(2);
    probe({36'h40, 12'h8}, 1, 0, rdy); check(rdy, "R9 ordered write after completion", 64'(rdy), 1);

    // R6 back-pressure
    out_ready = 0;
    send({36'h10, 12'h0AB}, 0, 0, 12'd2);
    check(out_valid && out_addr == {36'h800, 12'h0AB}, "R6 output loaded", 64'(out_addr),
          64'({36'h800, 12'h0AB}));
    probe({36'h11, 12'h0}, 0, 0, rdy); check(!rdy, "R6 hit blocked when full", 64'(rdy), 0);
    probe({36'h99, 12'h0}, 0, 0, rdy); check(rdy, "R5 miss accepted when full", 64'(rdy), 1);
    @(negedge clk);
    check(out_valid && out_addr == {36'h800, 12'h0AB}, "R6 output held", 64'(out_addr),
          64'({36'h800, 12'h0AB}));
    send({36'h99, 12'h0}, 0, 0, 12'd1);
    check(miss_o && out_addr == {36'h800, 12'h0AB}, "R5 miss leaves output", 64'(out_addr),
          64'({36'h800, 12'h0AB}));
    out_ready = 1;
    @(negedge clk);
    check(!out_valid, "R6 drained", 64'(out_valid), 0);

    // R2 disabling a window
    set_win(2, 0, 2'd2, 4'd3, 36'h40, 36'd1, 36'hABCDE);
    expect_rd({36'h40, 12'h0}, 12'd1);

    summary();
  end
endmodule